// File: doc/BRIEF.md
# Masked Frame-Header Nibble Aligner

This block receives a serial bit stream that has already been cut into 4-bit words on a parallel clock. The cut points are arbitrary. The block keeps a short history of the received bits and compares it, in every cycle, with a programmable 32-bit frame header at each of the four possible bit offsets inside a word. A per-bit mask register turns any header bit into a don't-care. When the header is found, a one-cycle frame pulse is produced. If boundary search is armed at that moment, the block also locks its output selector to the offset where the header was found. From then on, `aligned_nib` carries the stream cut on true frame boundaries.

A rising edge of `align_en` arms the search. The search stays armed while `align_en` is high. After `align_en` falls, the search stays armed until the next frame pulse, which still realigns the output. While the search is not armed, the locked offset is kept and frame pulses still appear whenever the header shows up at that offset. Header and mask bytes are loaded through a simple byte-wide write port.

Top module: `nib_frame_aligner`

## Requirements
- R1: After reset, `frame_pulse` and `aligned_nib` are 0 and the locked offset is 0. The header is F6F62828h and all mask bits are 0.
- R2: A write with `cfg_we` high loads `cfg_wdata` into one byte at the next clock edge. Addresses B0h, B1h, B2h and B3h hold header bits 31:24, 23:16, 15:8 and 7:0. Addresses B4h, B5h, B6h and B7h hold the mask bits in the same order.
- R3: A mask bit of 1 makes the matching header bit a don't-care. A mask bit of 0 requires the received bit to equal the header bit.
- R4: Writes to any address outside B0h..B7h change neither the header nor the mask.
- R5: Bit 3 of `rx_nib` is the earliest received bit of its word. Header bit 31 is compared against the earliest of the 32 compared stream bits.
- R6: Let the last header bit arrive in the word taken at clock edge n. Then `frame_pulse` is high for exactly the one cycle that follows edge n+1.
- R7: Number the stream bits from 0 in order of arrival, with bit 0 being bit 3 of the word taken at edge 0. With a locked offset k, the word shown after edge p is stream bits 4p-16-k to 4p-13-k, earliest in bit 3. So in the pulse cycle of a realignment, the output carries bits 15:12 of the header, and later words follow in stream order.
- R8: A rising edge of `align_en` arms the search. `align_en` being high at the first sampled edge after reset also counts as a rising edge. A header found at any offset in the same cycle as the edge, or in any cycle while armed, pulses and relocks the offset. If several offsets match, the lowest one wins.
- R9: While the search is not armed, no relock occurs. A pulse occurs only for a header at the locked offset, and the output keeps that offset.
- R10: After `align_en` falls, the search stays armed up to and including the first frame pulse, which still relocks. After that pulse, headers at other offsets produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_nib | input | 4 | Received word, bit 3 earliest |
| align_en | input | 1 | Boundary-search enable; its rising edge arms the search |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| aligned_nib | output | 4 | Frame-aligned output word |
| frame_pulse | output | 1 | One-cycle pulse per detected header |

## Verification
Two events can fall on the same edge: the arming edge of `align_en` and the detection of a header at a new offset. Disarming can also fall on the edge that relocks. The bench raises `align_en` in exactly the cycle whose edge decides the pulse for a header placed three bits off the current lock. In another scenario it drops `align_en` and lets the next header, at yet another offset, arrive while the search is still armed. Correct behaviour is judged only at the ports: the pulse must appear in the predicted cycle, and the output words after it must follow the new offset. A later header at a different offset must then produce no pulse.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

  localparam logic [7:0]  NFA_HDR_BASE = 8'hB0;
  localparam logic [7:0]  NFA_MSK_BASE = 8'hB4;
  localparam logic [31:0] NFA_HDR_RST  = 32'hF6F6_2828;

  typedef enum logic {
    ARM_OFF = 1'b0,
    ARM_ON  = 1'b1
  } arm_state_e;

endpackage

// File: rtl/nfa_cfg_regs.sv
module nfa_cfg_regs #(
  parameter int PAT_W  = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HDR_BASE = 8'hB0,
  parameter logic [ADDR_W-1:0] MSK_BASE = 8'hB4,
  parameter logic [PAT_W-1:0]  HDR_RST  = 32'hF6F6_2828
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [PAT_W-1:0]  hdr,
  output logic [PAT_W-1:0]  msk
);

  localparam int NBYTES = PAT_W / 8;

  logic [PAT_W-1:0] hdr_q, hdr_d;
  logic [PAT_W-1:0] msk_q, msk_d;

  // byte i sits at base+i, byte 0 is the most significant
  always_comb begin
    hdr_d = hdr_q;
    msk_d = msk_q;
    for (int i = 0; i < NBYTES; i++) begin
      if (we && (addr == HDR_BASE + ADDR_W'(i)))
        hdr_d[PAT_W-1-8*i -: 8] = wdata;
      if (we && (addr == MSK_BASE + ADDR_W'(i)))
        msk_d[PAT_W-1-8*i -: 8] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= HDR_RST;
      msk_q <= '0;
    end else begin
      hdr_q <= hdr_d;
      msk_q <= msk_d;
    end
  end

  assign hdr = hdr_q;
  assign msk = msk_q;

endmodule

// File: rtl/nfa_matcher.sv
module nfa_matcher #(
  parameter int NIB_W = 4,
  parameter int PAT_W = 32,
  localparam int HIST_W = PAT_W + NIB_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  rx_nib,
  input  logic [PAT_W-1:0]  hdr,
  input  logic [PAT_W-1:0]  msk,
  output logic [HIST_W-1:0] hist,
  output logic [NIB_W-1:0]  match_vec
);

  logic [HIST_W-1:0] hist_q, hist_d;

  // newest bit lands in bit 0, so older bits sit higher
  always_comb begin
    hist_d = {hist_q[HIST_W-NIB_W-1:0], rx_nib};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // offset k: header ends k bits before the newest bit
  for (genvar k = 0; k < NIB_W; k++) begin : g_lane
    assign match_vec[k] = ~|((hist_q[k +: PAT_W] ^ hdr) & ~msk);
  end

  assign hist = hist_q;

endmodule

// File: rtl/nfa_align_ctrl.sv
module nfa_align_ctrl
  import nfa_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int OFF_W = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align_en,
  input  logic [NIB_W-1:0] match_vec,
  output logic [OFF_W-1:0] off_nxt,
  output logic [OFF_W-1:0] off_q,
  output logic             armed,
  output logic             en_q,
  output logic             pulse_evt,
  output logic             frame_pulse
);

  arm_state_e       st_q, st_d;
  logic             en_rise, arm_now, hit_any;
  logic [OFF_W-1:0] hit_idx;

  // lowest matching offset has priority
  always_comb begin
    hit_any = |match_vec;
    hit_idx = '0;
    for (int k = NIB_W - 1; k >= 0; k--) begin
      if (match_vec[k]) hit_idx = OFF_W'(k);
    end
  end

  always_comb begin
    en_rise   = align_en & ~en_q;
    arm_now   = (st_q == ARM_ON) | en_rise;
    pulse_evt = arm_now ? hit_any : match_vec[off_q];
    off_nxt   = (arm_now && hit_any) ? hit_idx : off_q;
    st_d      = (arm_now && !(!align_en && pulse_evt)) ? ARM_ON : ARM_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ARM_OFF;
      en_q        <= 1'b0;
      off_q       <= '0;
      frame_pulse <= 1'b0;
    end else begin
      st_q        <= st_d;
      en_q        <= align_en;
      off_q       <= off_nxt;
      frame_pulse <= pulse_evt;
    end
  end

  assign armed = (st_q == ARM_ON);

endmodule

// File: rtl/nfa_nib_select.sv
module nfa_nib_select #(
  parameter int NIB_W = 4,
  parameter int PAT_W = 32,
  localparam int HIST_W  = PAT_W + NIB_W - 1,
  localparam int OFF_W   = (NIB_W > 1) ? $clog2(NIB_W) : 1,
  localparam int TAP_LSB = PAT_W / 2 - NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] hist,
  input  logic [OFF_W-1:0]  sel,
  output logic [NIB_W-1:0]  nib_out
);

  logic [NIB_W-1:0] tap [NIB_W];
  logic [NIB_W-1:0] nib_d, nib_q;

  // tap k: the word that begins with header bit PAT_W/2-1 at offset k
  for (genvar k = 0; k < NIB_W; k++) begin : g_tap
    assign tap[k] = hist[k + TAP_LSB +: NIB_W];
  end

  always_comb begin
    nib_d = tap[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nib_q <= '0;
    else        nib_q <= nib_d;
  end

  assign nib_out = nib_q;

endmodule

// File: rtl/nib_frame_aligner.sv
module nib_frame_aligner
  import nfa_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int PAT_W  = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HDR_BASE = NFA_HDR_BASE,
  parameter logic [ADDR_W-1:0] MSK_BASE = NFA_MSK_BASE,
  parameter logic [PAT_W-1:0]  HDR_RST  = NFA_HDR_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  rx_nib,
  input  logic              align_en,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [NIB_W-1:0]  aligned_nib,
  output logic              frame_pulse
);

  localparam int HIST_W = PAT_W + NIB_W - 1;
  localparam int OFF_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [PAT_W-1:0]  hdr, msk;
  logic [HIST_W-1:0] hist;
  logic [NIB_W-1:0]  match_vec;
  logic [OFF_W-1:0]  off_nxt, off_q;
  logic              armed, en_q, pulse_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  nfa_cfg_regs #(
    .PAT_W(PAT_W), .ADDR_W(ADDR_W),
    .HDR_BASE(HDR_BASE), .MSK_BASE(MSK_BASE), .HDR_RST(HDR_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .hdr(hdr), .msk(msk)
  );

  nfa_matcher #(.NIB_W(NIB_W), .PAT_W(PAT_W)) u_match (
    .clk(clk), .rst_n(rst_sync_n), .rx_nib(rx_nib), .hdr(hdr), .msk(msk),
    .hist(hist), .match_vec(match_vec)
  );

  nfa_align_ctrl #(.NIB_W(NIB_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .align_en(align_en), .match_vec(match_vec),
    .off_nxt(off_nxt), .off_q(off_q), .armed(armed), .en_q(en_q),
    .pulse_evt(pulse_evt), .frame_pulse(frame_pulse)
  );

  nfa_nib_select #(.NIB_W(NIB_W), .PAT_W(PAT_W)) u_sel (
    .clk(clk), .rst_n(rst_sync_n), .hist(hist), .sel(off_nxt),
    .nib_out(aligned_nib)
  );

endmodule

// File: rtl/nfa_checker.sv
module nfa_checker #(
  parameter int NIB_W  = 4,
  parameter int PAT_W  = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HDR_BASE = 8'hB0,
  parameter logic [ADDR_W-1:0] MSK_BASE = 8'hB4,
  localparam int OFF_W = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              align_en,
  input logic              en_q,
  input logic              armed,
  input logic              pulse_evt,
  input logic [NIB_W-1:0]  match_vec,
  input logic [OFF_W-1:0]  off_q,
  input logic              frame_pulse,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [PAT_W-1:0]  hdr,
  input logic [PAT_W-1:0]  msk
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = MSK_BASE + ADDR_W'(PAT_W / 8);

  a_r8_arm_on_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (align_en && !en_q) |=> armed);

  a_r10_disarm_on_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && !align_en && pulse_evt) |=> !armed);

  a_r9_offset_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!armed && !(align_en && !en_q)) |=> $stable(off_q));

  a_r6_pulse_from_match: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_pulse |-> $past(|match_vec));

  a_r2_header_msb_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_addr == HDR_BASE) |=> (hdr[PAT_W-1 -: 8] == $past(cfg_wdata)));

  a_r4_stray_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && (cfg_addr < HDR_BASE || cfg_addr >= TOP_ADDR)) |=> ($stable(hdr) && $stable(msk)));

endmodule

bind nib_frame_aligner nfa_checker #(
  .NIB_W(NIB_W), .PAT_W(PAT_W), .ADDR_W(ADDR_W),
  .HDR_BASE(HDR_BASE), .MSK_BASE(MSK_BASE)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .align_en(align_en), .en_q(en_q),
  .armed(armed), .pulse_evt(pulse_evt), .match_vec(match_vec), .off_q(off_q),
  .frame_pulse(frame_pulse), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .hdr(hdr), .msk(msk)
);

// File: tb/tb_nib_frame_aligner.sv
`timescale 1ns/100ps
module tb_nib_frame_aligner;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] rx_nib;
  logic       align_en;
  logic       cfg_we;
  logic [7:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [3:0] aligned_nib;
  logic       frame_pulse;

  int n_run  = 0;
  int n_fail = 0;

  bit sbits  [0:255];
  bit exp_pl [0:63];
  int exp_off[0:63];
  bit en_arr [0:63];

  always #2.5 clk = ~clk;

  nib_frame_aligner dut (
    .clk(clk), .rst_n(rst_n), .rx_nib(rx_nib), .align_en(align_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .aligned_nib(aligned_nib), .frame_pulse(frame_pulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_nib = '0; align_en = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int i = 0; i < 256; i++) sbits[i] = 1'b0;
    for (int i = 0; i < 64; i++) begin
      exp_pl[i] = 1'b0; exp_off[i] = 0; en_arr[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic place(input int s, input logic [31:0] w);
    for (int j = 0; j < 32; j++) sbits[s + j] = w[31 - j];
  endtask

  // header whose last bit is stream bit e: pulse after push e/4+1
  task automatic expect_frame(input int e, input bit relock, input int n);
    int p;
    p = e / 4 + 1;
    exp_pl[p] = 1'b1;
    if (relock)
      for (int q = p; q < n; q++) exp_off[q] = 3 - (e % 4);
  endtask

  function automatic logic [3:0] exp_nib(input int p);
    logic [3:0] r;
    int b0;
    b0 = 4 * p - 16 - exp_off[p];
    for (int j = 0; j < 4; j++)
      r[3 - j] = (b0 + j >= 0) ? sbits[b0 + j] : 1'b0;
    return r;
  endfunction

  task automatic play(input int n, input string req);
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      rx_nib   = {sbits[4*p], sbits[4*p+1], sbits[4*p+2], sbits[4*p+3]};
      align_en = en_arr[p];
      @(posedge clk);
      #1;
      check(frame_pulse == exp_pl[p], req, $sformatf("pulse after push %0d", p),
            frame_pulse, exp_pl[p]);
      check(aligned_nib == exp_nib(p), req, $sformatf("word after push %0d", p),
            aligned_nib, exp_nib(p));
    end
    @(negedge clk);
    rx_nib = '0; align_en = 1'b0;
  endtask

  // R1: reset state at the ports
  task automatic t_reset();
    do_reset();
    check(frame_pulse == 1'b0, "R1", "pulse at reset", frame_pulse, 0);
    check(aligned_nib == 4'h0, "R1", "word at reset", aligned_nib, 0);
  endtask

  // R5 R6 R7 R8: armed relock at two different offsets
  task automatic t_armed_relock();
    do_reset();
    for (int p = 0; p < 40; p++) en_arr[p] = 1'b1;
    place(5, 32'hF6F6_2828);  place(37, 32'hA5C3_9E17);
    place(70, 32'hF6F6_2828); place(102, 32'h3C5A_0FF1);
    expect_frame(36, 1'b1, 40);
    expect_frame(101, 1'b1, 40);
    play(40, "R5 R6 R7 R8");
  endtask

  // R1 R9: not armed, default header, offset 0 kept
  task automatic t_unarmed();
    do_reset();
    place(4, 32'hF6F6_2828);  place(36, 32'hA5C3_9E17);
    place(50, 32'hF6F6_2828);
    expect_frame(35, 1'b0, 30);
    play(30, "R9");
  endtask

  // R10: disarm only by the first pulse after enable falls
  task automatic t_disarm();
    do_reset();
    for (int p = 0; p < 15; p++) en_arr[p] = 1'b1;
    place(5, 32'hF6F6_2828);   place(37, 32'hA5C3_9E17);
    place(70, 32'hF6F6_2828);  place(102, 32'h3C5A_0FF1);
    place(139, 32'hF6F6_2828);
    expect_frame(36, 1'b1, 48);
    expect_frame(101, 1'b1, 48);
    play(48, "R10");
  endtask

  // R8: enable edge in the same cycle as a header at a new offset
  task automatic t_edge_meets_header();
    do_reset();
    for (int p = 10; p < 32; p++) en_arr[p] = 1'b1;
    place(5, 32'hF6F6_2828);  place(37, 32'h9E17_A5C3);
    place(70, 32'hF6F6_2828);
    expect_frame(36, 1'b1, 32);
    expect_frame(101, 1'b1, 32);
    play(32, "R8");
  endtask

  // R2 R3: programmed header with masked bits
  task automatic t_masked();
    do_reset();
    cfg_write(8'hB0, 8'h12); cfg_write(8'hB1, 8'h34);
    cfg_write(8'hB2, 8'h56); cfg_write(8'hB3, 8'h78);
    cfg_write(8'hB4, 8'h0F); cfg_write(8'hB5, 8'h00);
    cfg_write(8'hB6, 8'h00); cfg_write(8'hB7, 8'hFF);
    place(0, 32'h1834_562D);    // differs only under mask
    place(64, 32'hF6F6_2828);   // old default no longer matches
    place(128, 32'h1224_5678);  // differs in an unmasked bit
    expect_frame(31, 1'b0, 44);
    play(44, "R2 R3");
  endtask

  // R4: stray addresses leave the default header intact
  task automatic t_stray_write();
    do_reset();
    cfg_write(8'hAF, 8'h00); cfg_write(8'hB8, 8'h00);
    cfg_write(8'h00, 8'h00); cfg_write(8'hFF, 8'hFF);
    place(0, 32'hF6F6_2828);
    expect_frame(31, 1'b0, 14);
    play(14, "R4");
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_armed_relock();
    t_unarmed();
    t_disarm();
    t_edge_meets_header();
    t_masked();
    t_stray_write();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog all requirements: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule